// File: doc/BRIEF.md
# Dependence-steered FIFO issue queue

This block holds decoded instructions that wait for their source operands. It does not use one large window that every completing result must reach. Instead it keeps a small set of strictly in-order FIFOs. At dispatch each instruction is steered so that a chain of dependent instructions lines up in one FIFO. Only the head of each FIFO is checked for readiness, and every ready head may leave in the same cycle.

Steering uses two structures. The first is a table indexed by logical register: it names the FIFO and the physical tag of the most recent queued producer of that register. The second is one availability bit per physical register. A dispatched destination clears its bit, and a completion write sets it. Upstream logic presents at most one instruction per cycle. When no FIFO can take the instruction, the block raises a stall, and upstream holds the instruction for a later cycle. Renaming and execution belong to the neighbouring blocks.

Top module: `dep_fifo_iq`

## Requirements
- R1: After reset all FIFOs are empty, `iss_valid` is 0, `disp_stall` is 0, and every physical register is marked available.
- R2: An instruction with no outstanding operand goes into the lowest-numbered empty FIFO. An operand is outstanding when its source is enabled and the availability bit of its physical tag is 0.
- R3: An instruction whose steering operand is outstanding is appended to the FIFO that the table names for that operand's logical register. This happens only when that FIFO's last entry is the producer (same destination tag) and the FIFO is not full.
- R4: The instruction goes into the lowest-numbered empty FIFO in three cases: something already sits behind the producer, the producer's FIFO is full, or the producer has already issued. An issuing producer clears its table entry.
- R5: When both sources are outstanding, source 0 is the steering operand.
- R6: With `disp_valid` high and no FIFO able to take the instruction, `disp_stall` is 1 in that same cycle and the instruction is not accepted.
- R7: A head issues only when every enabled source's availability bit is 1. A completion written at a clock edge lets a waiting head issue in the cycle after that edge.
- R8: Each FIFO issues in dispatch order. Every ready head raises `iss_valid[q]` in the same cycle. An instruction accepted at an edge can raise `iss_valid` in the cycle after that edge. `iss_dst_ptag` field q (bits q*6 upward) carries the head's destination tag.
- R9: Accepting an instruction with an enabled destination clears that tag's availability bit. A completion on `done_ptag` sets it. If both hit the same tag in one cycle, the allocation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_src_en | input | 2 | Source enables; bit i for source i |
| disp_src_lreg | input | 10 | Logical source registers; source i at bits [5i+4:5i] |
| disp_src_ptag | input | 12 | Physical source tags; source i at bits [6i+5:6i] |
| disp_dst_en | input | 1 | Instruction writes a destination |
| disp_dst_lreg | input | 5 | Logical destination register |
| disp_dst_ptag | input | 6 | Physical destination tag |
| disp_stall | output | 1 | Offered instruction not accepted this cycle |
| done_valid | input | 1 | Completion write valid |
| done_ptag | input | 6 | Physical tag whose value became available |
| iss_valid | output | 8 | Bit q: head of FIFO q issues this cycle |
| iss_dst_ptag | output | 48 | Destination tag of each FIFO head, 6 bits per FIFO |

## Verification
The bench builds dependence chains and checks which FIFO bit lights up when each chain is released. A design that ignored the tail condition would put a second consumer behind the first, and the two would then issue in successive cycles instead of together. The bench fills one FIFO to its depth, so a design that appended to a full FIFO would lose or overwrite an entry. The bench gives an instruction two outstanding sources whose producers sit in different FIFOs, which shows whether source 0 decides the steering. It also holds a completion and looks at the issue outputs in the same cycle, where an early wakeup would show. Last, it fills every FIFO and checks that the stall appears and that the refused instruction never issues afterwards.

// File: rtl/iq_pkg.sv
// Shared sizes and the queue entry layout for the dependence-steered issue queue.
package iq_pkg;
    parameter int LREG_N = 32;
    parameter int PREG_N = 64;
    localparam int LREG_W = $clog2(LREG_N);
    localparam int PTAG_W = $clog2(PREG_N);

    typedef struct packed {
        logic [1:0]             src_en;
        logic [1:0][PTAG_W-1:0] src_ptag;
        logic                   dst_en;
        logic [LREG_W-1:0]      dst_lreg;
        logic [PTAG_W-1:0]      dst_ptag;
    } iq_entry_t;
endpackage

// File: rtl/iq_fifo.sv
// One in-order instruction FIFO. Shows its oldest entry (head) and its newest
// entry (tail). Assumes the caller never pushes when full or pops when empty.
module iq_fifo
    import iq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  iq_entry_t din,
    input  logic      pop,
    output logic      empty,
    output logic      full,
    output iq_entry_t head,
    output iq_entry_t tail
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    iq_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];
    assign tail  = mem[(wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1];

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r8_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !pop) |=> $stable(head));
endmodule

// File: rtl/iq_resv.sv
// Availability bit per physical register: set by completion, cleared by a new
// destination allocation (allocation wins on the same tag). All set at reset.
module iq_resv
    import iq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [PTAG_W-1:0] alloc_ptag,
    input  logic              done_en,
    input  logic [PTAG_W-1:0] done_ptag,
    output logic [PREG_N-1:0] ready
);
    // Update the availability bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= '1;
        end else begin
            if (done_en)  ready[done_ptag]  <= 1'b1;
            if (alloc_en) ready[alloc_ptag] <= 1'b0;
        end
    end

    a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (done_en && !(alloc_en && alloc_ptag == done_ptag)) |=> ready[$past(done_ptag)]);
    a_r9_alloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> !ready[$past(alloc_ptag)]);
endmodule

// File: rtl/iq_steer.sv
// Chooses the FIFO for a dispatching instruction. It joins the producer's FIFO
// when the producer is its tail and there is room; otherwise it takes the
// lowest empty FIFO. Purely combinational.
module iq_steer
    import iq_pkg::*;
#(
    parameter int NUM_Q = 8,
    localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                        cand_valid,
    input  logic                        cand_mapped,
    input  logic [QID_W-1:0]            cand_q,
    input  logic [PTAG_W-1:0]           cand_ptag,
    input  logic [NUM_Q-1:0]            q_empty,
    input  logic [NUM_Q-1:0]            q_full,
    input  logic [NUM_Q-1:0]            tail_dst_en,
    input  logic [NUM_Q-1:0][PTAG_W-1:0] tail_ptag,
    output logic                        tgt_ok,
    output logic [QID_W-1:0]            tgt_q
);
    logic             join_ok;
    logic             free_found;
    logic [QID_W-1:0] free_q;

    // Producer still at the tail of a FIFO with room.
    assign join_ok = cand_valid && cand_mapped && !q_empty[cand_q] && !q_full[cand_q]
                     && tail_dst_en[cand_q] && (tail_ptag[cand_q] == cand_ptag);

    // Lowest-numbered empty FIFO.
    always_comb begin
        free_found = 1'b0;
        free_q     = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (q_empty[i]) begin
                free_found = 1'b1;
                free_q     = QID_W'(i);
            end
        end
    end

    assign tgt_ok = join_ok || free_found;
    assign tgt_q  = join_ok ? cand_q : free_q;
endmodule

// File: rtl/dep_fifo_iq.sv
// Dependence-steered issue queue: NUM_Q in-order FIFOs of DEPTH entries. A
// logical-register table locates queued producers; availability bits gate the
// FIFO heads. Assumes upstream holds the instruction while disp_stall is high.
module dep_fifo_iq
    import iq_pkg::*;
#(
    parameter int NUM_Q = 8,
    parameter int DEPTH = 8,
    localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_valid,
    input  logic [1:0]              disp_src_en,
    input  logic [2*LREG_W-1:0]     disp_src_lreg,
    input  logic [2*PTAG_W-1:0]     disp_src_ptag,
    input  logic                    disp_dst_en,
    input  logic [LREG_W-1:0]       disp_dst_lreg,
    input  logic [PTAG_W-1:0]       disp_dst_ptag,
    output logic                    disp_stall,
    input  logic                    done_valid,
    input  logic [PTAG_W-1:0]       done_ptag,
    output logic [NUM_Q-1:0]        iss_valid,
    output logic [NUM_Q*PTAG_W-1:0] iss_dst_ptag
);
    logic [PREG_N-1:0]             ready;
    logic [NUM_Q-1:0]              q_empty, q_full, q_push, tail_den;
    logic [NUM_Q-1:0][PTAG_W-1:0]  tail_ptag;
    iq_entry_t                     q_head [NUM_Q];
    iq_entry_t                     q_tail [NUM_Q];
    iq_entry_t                     din;

    logic [LREG_N-1:0]             map_v;
    logic [QID_W-1:0]              map_q [LREG_N];
    logic [PTAG_W-1:0]             map_p [LREG_N];

    logic [1:0]                    src_out;
    logic [LREG_W-1:0]             cand_lreg;
    logic [PTAG_W-1:0]             cand_ptag;
    logic                          cand_mapped, tgt_ok, disp_fire;
    logic [QID_W-1:0]              tgt_q;

    // Classify each source as outstanding and pick the steering operand (source 0 first).
    always_comb begin
        for (int s = 0; s < 2; s++)
            src_out[s] = disp_src_en[s] && !ready[disp_src_ptag[s*PTAG_W +: PTAG_W]];
        if (src_out[0]) begin
            cand_lreg = disp_src_lreg[0 +: LREG_W];
            cand_ptag = disp_src_ptag[0 +: PTAG_W];
        end else begin
            cand_lreg = disp_src_lreg[LREG_W +: LREG_W];
            cand_ptag = disp_src_ptag[PTAG_W +: PTAG_W];
        end
    end

    assign cand_mapped = map_v[cand_lreg] && (map_p[cand_lreg] == cand_ptag);
    assign disp_fire   = disp_valid && tgt_ok;
    assign disp_stall  = disp_valid && !tgt_ok;

    // Assemble the entry to push.
    always_comb begin
        din.src_en   = disp_src_en;
        din.src_ptag = disp_src_ptag;
        din.dst_en   = disp_dst_en;
        din.dst_lreg = disp_dst_lreg;
        din.dst_ptag = disp_dst_ptag;
    end

    iq_steer #(.NUM_Q(NUM_Q)) i_steer (
        .cand_valid (|src_out),
        .cand_mapped(cand_mapped),
        .cand_q     (map_q[cand_lreg]),
        .cand_ptag  (cand_ptag),
        .q_empty    (q_empty),
        .q_full     (q_full),
        .tail_dst_en(tail_den),
        .tail_ptag  (tail_ptag),
        .tgt_ok     (tgt_ok),
        .tgt_q      (tgt_q)
    );

    iq_resv i_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (disp_fire && disp_dst_en),
        .alloc_ptag(disp_dst_ptag),
        .done_en   (done_valid),
        .done_ptag (done_ptag),
        .ready     (ready)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic hrdy;

        // Head is ready when every enabled source is available.
        always_comb begin
            hrdy = !q_empty[g];
            for (int s = 0; s < 2; s++)
                if (q_head[g].src_en[s] && !ready[q_head[g].src_ptag[s]]) hrdy = 1'b0;
        end

        assign q_push[g]    = disp_fire && (tgt_q == QID_W'(g));
        assign iss_valid[g] = hrdy;
        assign iss_dst_ptag[g*PTAG_W +: PTAG_W] = q_head[g].dst_ptag;
        assign tail_den[g]  = q_tail[g].dst_en;
        assign tail_ptag[g] = q_tail[g].dst_ptag;

        iq_fifo #(.DEPTH(DEPTH)) i_fifo (
            .clk  (clk),
            .rst_n(rst_n),
            .push (q_push[g]),
            .din  (din),
            .pop  (hrdy),
            .empty(q_empty[g]),
            .full (q_full[g]),
            .head (q_head[g]),
            .tail (q_tail[g])
        );
    end

    // Map valid bits: cleared when the recorded producer issues, set on dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_v <= '0;
        end else begin
            for (int q = 0; q < NUM_Q; q++)
                if (iss_valid[q] && q_head[q].dst_en
                    && map_p[q_head[q].dst_lreg] == q_head[q].dst_ptag)
                    map_v[q_head[q].dst_lreg] <= 1'b0;
            if (disp_fire && disp_dst_en) map_v[disp_dst_lreg] <= 1'b1;
        end
    end

    // Map payload: producer FIFO and tag of the newest writer.
    always_ff @(posedge clk) begin
        if (disp_fire && disp_dst_en) begin
            map_q[disp_dst_lreg] <= tgt_q;
            map_p[disp_dst_lreg] <= disp_dst_ptag;
        end
    end

    a_r6_stall_all_busy: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall |-> (q_empty == '0));
    a_r2_ready_to_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && !(|src_out)) |-> q_empty[tgt_q]);
    a_r5_first_source: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && src_out[0] && !q_empty[tgt_q])
            |-> (q_tail[tgt_q].dst_ptag == disp_src_ptag[0 +: PTAG_W]));
    a_r3_join_room: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && !q_empty[tgt_q]) |-> (!q_full[tgt_q] && q_tail[tgt_q].dst_en));
endmodule

// File: tb/test_dep_fifo_iq.sv
module test_dep_fifo_iq;
    import iq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [1:0]  disp_src_en = '0;
    logic [9:0]  disp_src_lreg = '0;
    logic [11:0] disp_src_ptag = '0;
    logic        disp_dst_en = 1'b0;
    logic [4:0]  disp_dst_lreg = '0;
    logic [5:0]  disp_dst_ptag = '0;
    logic        disp_stall;
    logic        done_valid = 1'b0;
    logic [5:0]  done_ptag = '0;
    logic [7:0]  iss_valid;
    logic [47:0] iss_dst_ptag;

    int checks = 0;
    int bad = 0;

    dep_fifo_iq i_dep_fifo_iq (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ptag_of(input int q);
        return int'(iss_dst_ptag[q*6 +: 6]);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Offer one instruction; expects acceptance; returns at the next negedge.
    task automatic disp(input bit s0e, input int s0l, input int s0p,
                        input bit s1e, input int s1l, input int s1p,
                        input bit de, input int dl, input int dp);
        disp_valid    = 1'b1;
        disp_src_en   = {s1e, s0e};
        disp_src_lreg = {5'(s1l), 5'(s0l)};
        disp_src_ptag = {6'(s1p), 6'(s0p)};
        disp_dst_en   = de;
        disp_dst_lreg = 5'(dl);
        disp_dst_ptag = 6'(dp);
        #1 chk("R6 no stall with free room", int'(disp_stall), 0);
        tick();
        disp_valid = 1'b0;
    endtask

    // Completion write; checks no early wakeup before the edge.
    task automatic done(input int p, input int iss_before);
        done_valid = 1'b1;
        done_ptag  = 6'(p);
        #1 chk("R7 completion not visible same cycle", int'(iss_valid), iss_before);
        tick();
        done_valid = 1'b0;
    endtask

    task automatic t_reset_and_ready();
        chk("R1 iss_valid after reset", int'(iss_valid), 0);
        chk("R1 stall after reset", int'(disp_stall), 0);
        // Source p63 never allocated, so it is available: goes to FIFO 0.
        disp(1, 3, 63, 0, 0, 0, 1, 1, 1);
        chk("R2 available instr in fifo0", int'(iss_valid), 8'b0000_0001);
        chk("R8 head dst tag", ptag_of(0), 1);
        tick();
        chk("R8 popped after issue", int'(iss_valid), 0);
    endtask

    task automatic t_chain_join();
        disp(1, 1, 1, 0, 0, 0, 1, 2, 2);   // Y -> fifo0 (producer issued, R4)
        disp(1, 2, 2, 0, 0, 0, 1, 3, 3);   // Z -> fifo0 behind Y (R3)
        disp(1, 2, 2, 0, 0, 0, 1, 4, 4);   // W -> fifo1, Z sits behind Y (R4)
        chk("R9 consumers wait on cleared tag", int'(iss_valid), 0);
        done(1, 0);
        chk("R7 head wakes after completion", int'(iss_valid), 8'b0000_0001);
        chk("R4 producer-issued consumer in fifo0", ptag_of(0), 2);
        tick();
        chk("R8 in-order: Z waits", int'(iss_valid), 0);
        done(2, 0);
        chk("R3 R4 Z in fifo0 and W in fifo1", int'(iss_valid), 8'b0000_0011);
        chk("R3 Z tag at fifo0", ptag_of(0), 3);
        chk("R4 W tag at fifo1", ptag_of(1), 4);
        tick();
        chk("R8 both drained", int'(iss_valid), 0);
    endtask

    task automatic t_two_sources();
        disp(0, 0, 0, 0, 0, 0, 1, 10, 20);  // blocker, issues at once
        tick();
        disp(1, 10, 20, 0, 0, 0, 1, 11, 21); // D1 -> fifo0
        disp(1, 10, 20, 0, 0, 0, 1, 12, 22); // D2 -> fifo1
        disp(1, 12, 22, 1, 11, 21, 1, 13, 23); // D3: source 0 -> fifo1
        done(20, 0);
        chk("R8 all ready heads issue together", int'(iss_valid), 8'b0000_0011);
        tick();
        chk("R5 D3 waits on both", int'(iss_valid), 0);
        done(21, 0);
        chk("R7 D3 still waits on source 0", int'(iss_valid), 0);
        done(22, 0);
        chk("R5 D3 issues from fifo1", int'(iss_valid), 8'b0000_0010);
        chk("R5 D3 tag", ptag_of(1), 23);
        tick();
    endtask

    task automatic t_full_fifo();
        disp(0, 0, 0, 0, 0, 0, 1, 20, 30);  // blocker
        tick();
        for (int i = 0; i < 9; i++)
            disp(1, 20 + i, 30 + i, 0, 0, 0, 1, 21 + i, 31 + i);
        chk("R4 chain parked", int'(iss_valid), 0);
        done(38, 0);
        chk("R4 ninth link went to fifo1", int'(iss_valid), 8'b0000_0010);
        chk("R4 ninth link tag", ptag_of(1), 39);
        tick();
        done(30, 0);
        chk("R3 chain head in fifo0", int'(iss_valid), 8'b0000_0001);
        chk("R3 chain head tag", ptag_of(0), 31);
        tick();
        chk("R8 next link waits", int'(iss_valid), 0);
    endtask

    task automatic t_stall();
        disp(0, 0, 0, 0, 0, 0, 1, 30, 50);  // blocker -> fifo1
        tick();
        for (int k = 1; k < 8; k++)
            disp(1, 30, 50, 0, 0, 0, 0, 0, 0);
        disp_valid    = 1'b1;
        disp_src_en   = 2'b00;
        disp_dst_en   = 1'b1;
        disp_dst_lreg = 5'd31;
        disp_dst_ptag = 6'd60;
        #1 chk("R6 stall when no fifo free", int'(disp_stall), 1);
        tick();
        disp_valid = 1'b0;
        #1 chk("R6 stall drops without request", int'(disp_stall), 0);
        done(50, 0);
        chk("R8 seven heads issue together", int'(iss_valid), 8'b1111_1110);
        tick();
        chk("R6 refused instruction never queued", int'(iss_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_ready();
        t_chain_join();
        t_two_sources();
        t_full_fifo();
        t_stall();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule